// File: doc/BRIEF.md
# Channel Host Service Request Scheduler

This block stores a small request code and an enable priority for each of a set of service channels, and hands pending work one thread at a time to a single service engine. The host programs either field of any channel through a one-cycle write strobe and can read both back through a combinational read port. A channel counts as pending when its request code is non-zero or when an outside request source (modelled as a level input per channel) is raised. A channel with a zero priority field is skipped, but its request is kept.

At each time-slot strobe, while no thread is outstanding, the scheduler samples every enabled, pending channel. It picks one with a round-robin pointer and latches the channel number, the sampled code and whether the thread is host-initiated. It offers these to the engine on a valid/ready start interface. `thr_valid` stays high, with channel and code held, until the engine raises `thr_ready`. There is no back-pressure towards the host: writes always land.

Once the engine accepts, the channel's busy bit is set. The engine ends the thread with a one-cycle `thr_done`. At that point the busy bit clears, and if the thread was host-initiated the channel's request code returns to zero. This clear overrides any host rewrite made during the thread, including one in the same cycle.

Top module: `chan_req_sched`

## Requirements
- R1: After reset every request code and priority field reads 0, `svc_busy` is all zero and `thr_valid` is low.
- R2: A write with `wr_prio`=0 stores `wr_data` (3 bits) as the request code of channel `wr_chan` only. A write with `wr_prio`=1 stores `wr_data[1:0]` as that channel's priority. Other channels are unchanged.
- R3: A request code of 0 with `ext_req` low means nothing is pending; a slot strobe then starts no thread.
- R4: A channel with priority 0 is never granted, and its non-zero request code is retained; once its priority is non-zero it is granted at the next strobe.
- R5: Among enabled pending channels the grant goes to the first at or after the round-robin pointer, scanning upward with wrap; after a grant the pointer moves to the granted channel plus one, modulo the channel count.
- R6: The grant samples register contents as of the strobe cycle, before that cycle's write. The last code written in an earlier cycle is the one offered, and a code rewritten to 0 with `ext_req` low starts no thread.
- R7: `thr_valid` rises the cycle after a granting strobe; while `thr_ready` is low it stays high with `thr_chan`, `thr_code` and `thr_host` unchanged.
- R8: The busy bit of the accepted channel is set from the cycle after acceptance until the cycle after `thr_done`, when it clears.
- R9: When a thread with `thr_host`=1 ends, the channel's request code becomes 0, even if the host wrote a non-zero code during the thread or in the `thr_done` cycle.
- R10: A thread started with a zero code via `ext_req` has `thr_host`=0, and its end leaves the channel's request code as the host last wrote it.
- R11: Writing a zero code to a channel whose thread is running does not end the thread; its busy bit stays set until `thr_done`.
- R12: At most one thread is offered or running at a time; slot strobes while one is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_prio | input | 1 | 0: write request code, 1: write priority |
| wr_chan | input | 3 | Channel addressed by the write |
| wr_data | input | 3 | Write data (priority uses bits 1:0) |
| rd_chan | input | 3 | Channel addressed by the readback |
| rd_code | output | 3 | Request code of `rd_chan` |
| rd_prio | output | 2 | Priority of `rd_chan` |
| ext_req | input | 8 | Per-channel requests from other sources |
| slot_tick | input | 1 | Time-slot transition strobe |
| thr_valid | output | 1 | Thread start offered |
| thr_ready | input | 1 | Engine accepts the offered thread |
| thr_chan | output | 3 | Granted channel |
| thr_code | output | 3 | Sampled request code for entry selection |
| thr_host | output | 1 | Thread was started by a host request |
| thr_done | input | 1 | End-of-thread strobe |
| svc_busy | output | 8 | Per-channel service-status bits |

## Verification
The bench sweeps every channel with every non-zero code and every subset of pending channels. A wrong pointer update would show up as a wrong grant order, and a leak in the write decode would show up as a neighbour changing. It rewrites codes just before the strobe, including to zero, which catches a scheduler that latches stale values or starts an empty thread. Host writes are made during running threads and in the same cycle as `thr_done`. A design where the write beats the clear would leave a request pending, and one that clears after a non-host thread would drop the host's code. It also masks channels with priority 0 and strobes during outstanding threads, where a faulty design would grant a disabled channel, discard its code, or offer a second thread.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int CODE_W = 3;
  localparam int PRIO_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_RUN   = 2'd2
  } sched_st_e;
endpackage

// File: rtl/chs_regfile.sv
module chs_regfile #(
  parameter int NCH  = 8,
  parameter int CW   = 3,
  parameter int PW   = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_prio,
  input  logic [CHW-1:0]          wr_chan,
  input  logic [CW-1:0]           wr_data,
  input  logic                    clr_en,
  input  logic [CHW-1:0]          clr_chan,
  output logic [NCH-1:0][CW-1:0]  code_o,
  output logic [NCH-1:0][PW-1:0]  prio_o
);
  logic [NCH-1:0][CW-1:0] code_q;
  logic [NCH-1:0][PW-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      prio_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        // end-of-thread clear outranks a host write in the same cycle
        if (clr_en && clr_chan == CHW'(i))
          code_q[i] <= '0;
        else if (wr_en && !wr_prio && wr_chan == CHW'(i))
          code_q[i] <= wr_data;
        if (wr_en && wr_prio && wr_chan == CHW'(i))
          prio_q[i] <= wr_data[PW-1:0];
      end
    end
  end

  assign code_o = code_q;
  assign prio_o = prio_q;

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> code_q[$past(clr_chan)] == '0);

  p_prio_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prio) |=> prio_q[$past(wr_chan)] == $past(wr_data[PW-1:0]));
endmodule

// File: rtl/chs_rr_arb.sv
module chs_rr_arb #(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!gnt_valid && req[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/chan_req_sched.sv
module chan_req_sched #(
  parameter int NCH  = 8,
  localparam int CHW = $clog2(NCH),
  localparam int CW  = chs_pkg::CODE_W,
  localparam int PW  = chs_pkg::PRIO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_prio,
  input  logic [CHW-1:0]  wr_chan,
  input  logic [CW-1:0]   wr_data,
  input  logic [CHW-1:0]  rd_chan,
  output logic [CW-1:0]   rd_code,
  output logic [PW-1:0]   rd_prio,
  input  logic [NCH-1:0]  ext_req,
  input  logic            slot_tick,
  output logic            thr_valid,
  input  logic            thr_ready,
  output logic [CHW-1:0]  thr_chan,
  output logic [CW-1:0]   thr_code,
  output logic            thr_host,
  input  logic            thr_done,
  output logic [NCH-1:0]  svc_busy
);
  import chs_pkg::*;

  logic [NCH-1:0][CW-1:0] code_w;
  logic [NCH-1:0][PW-1:0] prio_w;
  logic [NCH-1:0]         cand;
  logic                   gnt_valid;
  logic [CHW-1:0]         gnt_idx;
  logic                   clr_en;

  sched_st_e      st_q;
  logic [CHW-1:0] ptr_q;
  logic [CHW-1:0] chan_q;
  logic [CW-1:0]  code_q;
  logic           host_q;
  logic [NCH-1:0] busy_q;

  chs_regfile #(.NCH(NCH), .CW(CW), .PW(PW)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_prio  (wr_prio),
    .wr_chan  (wr_chan),
    .wr_data  (wr_data),
    .clr_en   (clr_en),
    .clr_chan (chan_q),
    .code_o   (code_w),
    .prio_o   (prio_w)
  );

  // a channel competes when enabled and pending from any source
  for (genvar i = 0; i < NCH; i++) begin : g_cand
    assign cand[i] = (prio_w[i] != '0) && ((code_w[i] != '0) || ext_req[i]);
  end

  chs_rr_arb #(.N(NCH)) arb_i (
    .req       (cand),
    .ptr       (ptr_q),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      chan_q <= '0;
      code_q <= '0;
      host_q <= 1'b0;
      busy_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (slot_tick && gnt_valid) begin
          chan_q <= gnt_idx;
          code_q <= code_w[gnt_idx];
          host_q <= (code_w[gnt_idx] != '0);
          ptr_q  <= (gnt_idx == CHW'(NCH - 1)) ? '0 : gnt_idx + 1'b1;
          st_q   <= ST_OFFER;
        end
        ST_OFFER: if (thr_ready) begin
          busy_q[chan_q] <= 1'b1;
          st_q           <= ST_RUN;
        end
        ST_RUN: if (thr_done) begin
          busy_q <= '0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_en    = (st_q == ST_RUN) && thr_done && host_q;
  assign thr_valid = (st_q == ST_OFFER);
  assign thr_chan  = chan_q;
  assign thr_code  = code_q;
  assign thr_host  = host_q;
  assign svc_busy  = busy_q;
  assign rd_code   = code_w[rd_chan];
  assign rd_prio   = prio_w[rd_chan];

  p_single_thread_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_busy) && !(thr_valid && svc_busy != '0));

  p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid && !thr_ready) |=> thr_valid && $stable(thr_chan) &&
                                  $stable(thr_code) && $stable(thr_host));

  p_grant_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> prio_w[gnt_idx] != '0);

  p_busy_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_busy != '0 && !thr_done) |=> svc_busy == $past(svc_busy));

  p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_busy != '0 && thr_done) |=> svc_busy == '0);
endmodule

// File: tb/chan_req_sched_tb_top.sv
module chan_req_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_prio = 1'b0;
  logic [2:0] wr_chan = '0, wr_data = '0, rd_chan = '0;
  logic [2:0] rd_code;
  logic [1:0] rd_prio;
  logic [N-1:0] ext_req = '0;
  logic       slot_tick = 1'b0, thr_ready = 1'b0, thr_done = 1'b0;
  logic       thr_valid, thr_host;
  logic [2:0] thr_chan, thr_code;
  logic [N-1:0] svc_busy;

  int errors = 0;
  int checks = 0;
  int ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_req_sched #(.NCH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_prio(wr_prio),
    .wr_chan(wr_chan), .wr_data(wr_data), .rd_chan(rd_chan),
    .rd_code(rd_code), .rd_prio(rd_prio), .ext_req(ext_req),
    .slot_tick(slot_tick), .thr_valid(thr_valid), .thr_ready(thr_ready),
    .thr_chan(thr_chan), .thr_code(thr_code), .thr_host(thr_host),
    .thr_done(thr_done), .svc_busy(svc_busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input bit is_prio, input int ch, input int val);
    wr_en = 1'b1; wr_prio = is_prio; wr_chan = 3'(ch); wr_data = 3'(val);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, output int code, output int pr);
    rd_chan = 3'(ch); #1;
    code = int'(rd_code); pr = int'(rd_prio);
  endtask

  task automatic tick();
    slot_tick = 1'b1; cyc(); slot_tick = 1'b0;
  endtask

  function automatic int pick(input logic [N-1:0] m, input int p);
    for (int k = 0; k < N; k++) begin
      if (m[(p + k) % N]) return (p + k) % N;
    end
    return -1;
  endfunction

  // full thread: strobe, checked offer with stall, accept, done
  task automatic run_thread(input int ch, input int code, input bit host,
                            input string tag);
    tick();
    chk(thr_valid === 1'b1, "R7", "valid after strobe", int'(thr_valid), 1);
    chk(int'(thr_chan) == ch, tag, "granted channel", int'(thr_chan), ch);
    chk(int'(thr_code) == code, tag, "sampled code", int'(thr_code), code);
    chk(thr_host == host, "R10", "host flag", int'(thr_host), int'(host));
    cyc();
    chk(thr_valid === 1'b1 && int'(thr_chan) == ch, "R7", "held under stall",
        int'(thr_chan), ch);
    thr_ready = 1'b1; cyc(); thr_ready = 1'b0;
    chk(svc_busy == N'(1) << ch, "R8", "busy after accept", int'(svc_busy), 1 << ch);
    ptr = (ch + 1) % N;
    thr_done = 1'b1; cyc(); thr_done = 1'b0;
    chk(svc_busy == '0, "R8", "busy after done", int'(svc_busy), 0);
  endtask

  initial begin
    int c, p, exp_ch;
    logic [N-1:0] pend;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    for (int ch = 0; ch < N; ch++) begin
      rd(ch, c, p);
      chk(c == 0 && p == 0, "R1", "reset fields", c * 4 + p, 0);
    end
    chk(svc_busy == '0 && thr_valid == 1'b0, "R1", "reset outputs",
        int'(svc_busy), 0);

    // R3 nothing pending
    tick(); cyc();
    chk(thr_valid == 1'b0, "R3", "no thread when idle", int'(thr_valid), 1'b0);

    // R4 disabled channel keeps its request
    wr(1'b0, 3, 5);
    tick(); cyc();
    chk(thr_valid == 1'b0, "R4", "disabled not granted", int'(thr_valid), 0);
    rd(3, c, p);
    chk(c == 5, "R4", "disabled code kept", c, 5);
    for (int ch = 0; ch < N; ch++) wr(1'b1, ch, (ch % 3) + 1);
    for (int ch = 0; ch < N; ch++) begin
      rd(ch, c, p);
      chk(p == (ch % 3) + 1, "R2", "priority readback", p, (ch % 3) + 1);
    end
    run_thread(3, 5, 1'b1, "R4");
    rd(3, c, p);
    chk(c == 0, "R9", "code cleared after host thread", c, 0);

    // R2 / R9 sweep every channel and code
    for (int ch = 0; ch < N; ch++) begin
      for (int v = 1; v < 8; v++) begin
        wr(1'b0, ch, v);
        for (int o = 0; o < N; o++) begin
          rd(o, c, p);
          chk(c == ((o == ch) ? v : 0), "R2", "code isolation", c,
              (o == ch) ? v : 0);
        end
        run_thread(ch, v, 1'b1, "R2");
        rd(ch, c, p);
        chk(c == 0, "R9", "auto clear", c, 0);
      end
    end

    // R5 round-robin over every pending subset
    for (int m = 1; m < (1 << N); m++) begin
      pend = N'(m);
      for (int ch = 0; ch < N; ch++)
        if (pend[ch]) wr(1'b0, ch, (ch % 7) + 1);
      while (pend != '0) begin
        exp_ch = pick(pend, ptr);
        run_thread(exp_ch, (exp_ch % 7) + 1, 1'b1, "R5");
        pend[exp_ch] = 1'b0;
      end
    end

    // R6 rewrite before the strobe decides the code
    wr(1'b0, 2, 5);
    wr(1'b0, 2, 3);
    run_thread(2, 3, 1'b1, "R6");
    wr(1'b0, 4, 4);
    wr(1'b0, 4, 0);
    tick(); cyc();
    chk(thr_valid == 1'b0, "R6", "rewrite to zero starts nothing",
        int'(thr_valid), 0);

    // R9 / R11 / R12 writes during a host thread
    wr(1'b0, 6, 2);
    wr(1'b0, 1, 7);
    exp_ch = pick(N'(8'b0100_0010), ptr);
    tick();
    thr_ready = 1'b1; cyc(); thr_ready = 1'b0;
    ptr = (exp_ch + 1) % N;
    tick(); cyc();
    chk(thr_valid == 1'b0, "R12", "strobe ignored while running",
        int'(thr_valid), 0);
    wr(1'b0, exp_ch, 0);
    cyc();
    chk(svc_busy[exp_ch] == 1'b1, "R11", "zero write does not abort",
        int'(svc_busy), 1 << exp_ch);
    wr(1'b0, exp_ch, 6);
    // same-cycle write with done: clear wins
    wr_en = 1'b1; wr_prio = 1'b0; wr_chan = 3'(exp_ch); wr_data = 3'd4;
    thr_done = 1'b1; cyc(); wr_en = 1'b0; thr_done = 1'b0;
    rd(exp_ch, c, p);
    chk(c == 0, "R9", "clear beats host write", c, 0);
    exp_ch = (exp_ch == 1) ? 6 : 1;
    run_thread(exp_ch, (exp_ch == 1) ? 7 : 2, 1'b1, "R12");

    // R10 thread from the other source keeps host code
    ext_req[5] = 1'b1;
    run_thread(5, 0, 1'b0, "R10");
    ext_req[5] = 1'b0;
    ext_req[0] = 1'b1;
    tick();
    thr_ready = 1'b1; cyc(); thr_ready = 1'b0;
    ptr = 1;
    ext_req[0] = 1'b0;
    wr(1'b0, 0, 6);
    thr_done = 1'b1; cyc(); thr_done = 1'b0;
    rd(0, c, p);
    chk(c == 6, "R10", "code survives non-host end", c, 6);
    run_thread(0, 6, 1'b1, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: run hung act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule